// File: doc/BRIEF.md
# Vectored Maskable Interrupt Controller

This block collects five interrupt events for a small 8-bit processor core: two comparator outputs (taken as levels, with the falling transition counting as the event), two timer overflow pulses and one conversion-complete pulse from an analog-to-digital converter. Each event is latched in a request flag. Software controls a per-source enable and one master enable through two byte-wide control registers. The same registers also let software read and write the flags.

When the master enable is on, a flag is set, its source is enabled and the return-address stack has room, the controller issues a one-cycle acknowledge request to the core. The request carries a fixed vector address. In the same cycle the controller clears that source's flag and the master enable. It issues no further request until the core returns an acknowledge-taken strobe. A separate wake output signals any enabled pending flag, so a sleeping core can resume whatever the master enable holds.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both register read values are 0x00, ack_req_o is 0 and wake_o is 0. ack_req_o stays 0 while rst_n is low.
- R2: Register 0 (reg_sel=0) holds these bits: bit0 master enable, bit1 comparator-0 enable, bit2 comparator-1 enable, bit3 timer-0 enable, bit4 comparator-0 flag, bit5 comparator-1 flag, bit6 timer-0 flag. Bit7 reads 0. A write loads all defined bits on the next clock edge.
- R3: Register 1 (reg_sel=1) holds these bits: bit0 timer-1 enable, bit1 converter enable, bit4 timer-1 flag, bit5 converter flag. Bits 2, 3, 6 and 7 read 0.
- R4: A comparator flag is set at the first clock edge that samples its input low after it was sampled high. A rising transition sets nothing.
- R5: A one-cycle pulse on tmr_ovf_i[n] or adc_done_i sets the matching flag at the next clock edge.
- R6: A request is acknowledged only when the master enable, the source enable and the flag are all 1 and stack_full_i is 0. While stack_full_i is 1 the flag stays set, and the acknowledge follows at the first edge after stack_full_i drops.
- R7: ack_vec_o is 0x04 for comparator 0, 0x08 for comparator 1, 0x0C for timer 0, 0x10 for timer 1 and 0x14 for the converter.
- R8: ack_req_o is a one-cycle pulse. At the edge that raises it, the served flag and the master enable are cleared.
- R9: When several requests are eligible together, the lowest vector address wins.
- R10: After an acknowledge, no new acknowledge is issued until ack_taken_i has been seen at a clock edge. The earliest new acknowledge comes one edge after that.
- R11: Flags keep latching events while the master enable is 0. wake_o is 1 whenever any flag is set together with its source enable, whatever the master enable holds.
- R12: If a software write clears a flag in the same cycle that a hardware event sets it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_lvl_i | input | 2 | Comparator output levels |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| adc_done_i | input | 1 | Conversion-complete pulse |
| stack_full_i | input | 1 | Return-address stack has no room |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select, 0 or 1 |
| reg_wdata_i | input | 8 | Register write data |
| ctl0_o | output | 8 | Read value of register 0 |
| ctl1_o | output | 8 | Read value of register 1 |
| ack_req_o | output | 1 | Acknowledge request pulse |
| ack_vec_o | output | 5 | Vector address sent with the acknowledge |
| ack_taken_i | input | 1 | Core has taken the acknowledge |
| wake_o | output | 1 | Enabled request pending |

## Verification
A register write or a source event shows up in the read values one edge after it is driven. An acknowledge that this change makes possible rises one edge later again, so a source event produces its acknowledge two edges after the event. The bench drives every input one time unit after a rising edge and reads every output at the same offset after each following edge. Each check therefore names the exact edge count: flag set after one edge, acknowledge after the next, pulse gone after a third. Held states, such as a full stack or a missing taken strobe, are checked at every edge of the hold.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
    localparam int SRC_N    = 5;
    localparam int CMP_N    = 2;
    localparam int TMR_N    = 2;
    localparam int VEC_W    = 5;
    localparam int IDX_W    = $clog2(SRC_N);

    typedef struct packed {
        logic               gen;
        logic [SRC_N-1:0]   en;
        logic [SRC_N-1:0]   flg;
        logic               ack;
        logic [VEC_W-1:0]   vec;
        logic               busy;
    } ctl_state_t;
endpackage

// File: rtl/irq_fall_detect.sv
module irq_fall_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_fall
        assign fall_o[g] = prev_q[g] & ~lvl_i[g];
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o   = 1'b0;
        grant_o = '0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o      = 1'b1;
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vector_pkg::*;
#(
    parameter int VEC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_N-1:0] cmp_lvl_i,
    input  logic [TMR_N-1:0] tmr_ovf_i,
    input  logic             adc_done_i,
    input  logic             stack_full_i,
    input  logic             reg_wr_i,
    input  logic             reg_sel_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       ctl0_o,
    output logic [7:0]       ctl1_o,
    output logic             ack_req_o,
    output logic [VEC_W-1:0] ack_vec_o,
    input  logic             ack_taken_i,
    output logic             wake_o
);
    localparam int VEC_LO = VEC_STEP;
    localparam int VEC_HI = VEC_STEP * SRC_N;

    ctl_state_t        s_d, s_q;
    logic [CMP_N-1:0]  cmp_fall;
    logic [SRC_N-1:0]  hw_set;
    logic [SRC_N-1:0]  elig;
    logic              pick_any;
    logic [SRC_N-1:0]  pick_grant;
    logic [IDX_W-1:0]  pick_idx;

    irq_fall_detect #(.N(CMP_N)) u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (cmp_lvl_i),
        .fall_o (cmp_fall)
    );

    // source order sets priority: lowest index, lowest vector
    assign hw_set = {adc_done_i, tmr_ovf_i, cmp_fall};
    assign elig   = s_q.flg & s_q.en &
                    {SRC_N{s_q.gen & ~stack_full_i & ~s_q.busy}};

    irq_prio_pick #(.N(SRC_N), .IDX_W(IDX_W)) u_pick (
        .req_i   (elig),
        .any_o   (pick_any),
        .grant_o (pick_grant),
        .idx_o   (pick_idx)
    );

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        if (ack_taken_i) s_d.busy = 1'b0;
        if (reg_wr_i) begin
            if (!reg_sel_i) begin
                s_d.gen      = reg_wdata_i[0];
                s_d.en[2:0]  = reg_wdata_i[3:1];
                s_d.flg[2:0] = reg_wdata_i[6:4];
            end else begin
                s_d.en[4:3]  = reg_wdata_i[1:0];
                s_d.flg[4:3] = reg_wdata_i[5:4];
            end
        end
        if (pick_any) begin
            s_d.ack  = 1'b1;
            s_d.vec  = VEC_W'((32'(pick_idx) + 1) * VEC_STEP);
            s_d.flg  = s_d.flg & ~pick_grant;
            s_d.gen  = 1'b0;
            s_d.busy = 1'b1;
        end
        s_d.flg = s_d.flg | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl0_o    = {1'b0, s_q.flg[2:0], s_q.en[2:0], s_q.gen};
    assign ctl1_o    = {2'b00, s_q.flg[4:3], 2'b00, s_q.en[4:3]};
    assign ack_req_o = s_q.ack;
    assign ack_vec_o = s_q.vec;
    assign wake_o    = |(s_q.flg & s_q.en);

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |=> !ack_req_o);

    // R8
    ack_gen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |-> !ctl0_o[0]);

    // R6
    ack_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |-> !$past(stack_full_i));

    // R7
    ack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |-> (ack_vec_o % VEC_STEP == 0 &&
                       int'(ack_vec_o) >= VEC_LO && int'(ack_vec_o) <= VEC_HI));

    // R10
    ack_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req_o && !ack_taken_i) |=> !ack_req_o);

    // R1
    always @(posedge clk) begin
        if (!rst_n) reset_quiet_chk: assert (!ack_req_o);
    end
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp_lvl = 2'b11;
    logic [1:0] tmr_ovf = 2'b00;
    logic       adc_done = 1'b0;
    logic       stack_full = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] ctl0, ctl1;
    logic       ack_req, ack_taken = 1'b0, wake;
    logic [4:0] ack_vec;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_lvl_i(cmp_lvl), .tmr_ovf_i(tmr_ovf),
        .adc_done_i(adc_done), .stack_full_i(stack_full), .reg_wr_i(reg_wr),
        .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .ctl0_o(ctl0),
        .ctl1_o(ctl1), .ack_req_o(ack_req), .ack_vec_o(ack_vec),
        .ack_taken_i(ack_taken), .wake_o(wake)
    );

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic taken();
        ack_taken = 1'b1;
        tick();
        ack_taken = 1'b0;
    endtask

    function automatic int flag_of(input int s);
        return (s < 3) ? int'(ctl0[4+s]) : int'(ctl1[4+s-3]);
    endfunction

    initial begin
        #(10 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state, including while reset is held
        tick(); tick();
        chk(ack_req, 0, "R1 ack during reset");
        rst_n = 1'b1;
        tick();
        chk(ctl0, 8'h00, "R1 ctl0");
        chk(ctl1, 8'h00, "R1 ctl1");
        chk(ack_req, 0, "R1 ack");
        chk(wake, 0, "R1 wake");

        // R2 R3 layout and unused bits, with master enable off
        wr(1'b0, 8'hFE);
        chk(ctl0, 8'h7E, "R2 unused bit7 reads 0");
        wr(1'b1, 8'hFF);
        chk(ctl1, 8'h33, "R3 unused bits read 0");
        chk(ack_req, 0, "R11 no ack with master off");
        chk(wake, 1, "R11 wake with master off");
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
        chk(wake, 0, "R11 wake clears");

        // R4 R5 R7 R8: each source alone
        for (int s = 0; s < 5; s++) begin
            wr(1'b1, (s >= 3) ? 8'(1 << (s - 3)) : 8'h00);
            wr(1'b0, (s < 3) ? 8'(8'h01 | (1 << (s + 1))) : 8'h01);
            if (s < 2) cmp_lvl[s] = 1'b0;
            else if (s < 4) tmr_ovf[s-2] = 1'b1;
            else adc_done = 1'b1;
            tick();
            tmr_ovf = 2'b00; adc_done = 1'b0;
            chk(flag_of(s), 1, (s < 2) ? "R4 falling edge sets flag" : "R5 pulse sets flag");
            chk(ack_req, 0, "R8 ack not yet");
            tick();
            chk(ack_req, 1, "R8 ack raised");
            chk(ack_vec, (s + 1) * 4, "R7 vector");
            chk(flag_of(s), 0, "R8 flag cleared");
            chk(ctl0[0], 0, "R8 master cleared");
            tick();
            chk(ack_req, 0, "R8 one-cycle pulse");
            if (s < 2) begin
                cmp_lvl[s] = 1'b1;
                tick(); tick();
                chk(flag_of(s), 0, "R4 rising edge ignored");
            end
            taken();
        end

        // R9 R7 R2 R3: every combination of pending flags
        for (int m = 1; m < 32; m++) begin
            int lo, rest;
            lo = 0;
            while (((m >> lo) & 1) == 0) lo++;
            rest = m & ~(1 << lo);
            wr(1'b1, 8'(((m >> 3) & 3) << 4 | 3));
            wr(1'b0, 8'((m & 7) << 4 | 8'h0E));
            chk(ctl0, (m & 7) << 4 | 8'h0E, "R2 flag/enable bits");
            chk(ctl1, ((m >> 3) & 3) << 4 | 3, "R3 flag/enable bits");
            wr(1'b0, 8'((m & 7) << 4 | 8'h0F));
            chk(ack_req, 0, "R9 ack after write edge");
            tick();
            chk(ack_req, 1, "R9 ack raised");
            chk(ack_vec, (lo + 1) * 4, "R9 lowest vector wins");
            chk(ctl0, (rest & 7) << 4 | 8'h0E, "R9 only winner cleared ctl0");
            chk(ctl1, ((rest >> 3) & 3) << 4 | 3, "R9 only winner cleared ctl1");
            taken();
        end

        // R6 stack full holds request
        wr(1'b1, 8'h00);
        stack_full = 1'b1;
        wr(1'b0, 8'h49);
        for (int k = 0; k < 5; k++) begin
            tick();
            chk(ack_req, 0, "R6 blocked while stack full");
            chk(ctl0, 8'h49, "R6 request kept");
        end
        stack_full = 1'b0;
        tick();
        chk(ack_req, 1, "R6 ack after stack frees");
        chk(ack_vec, 8'h0C, "R6 vector");
        chk(ctl0, 8'h08, "R6 flag and master cleared");

        // R10 no new ack without taken strobe
        wr(1'b0, 8'h49);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(ack_req, 0, "R10 waits for taken");
        end
        ack_taken = 1'b1;
        tick();
        ack_taken = 1'b0;
        chk(ack_req, 0, "R10 not at taken edge");
        tick();
        chk(ack_req, 1, "R10 ack after taken");
        chk(ack_vec, 8'h0C, "R10 vector");
        taken();

        // R12 hardware set wins over software clear; R11 latch with master off
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h01);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h01;
        tmr_ovf[1] = 1'b1;
        tick();
        reg_wr = 1'b0; tmr_ovf = 2'b00;
        chk(ctl1, 8'h11, "R12 hardware set wins");
        chk(wake, 1, "R11 wake with master off");
        tick(); tick();
        chk(ack_req, 0, "R11 no ack with master off");
        chk(ctl1, 8'h11, "R11 flag kept");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule